// File: doc/BRIEF.md
# Serial-to-Byte Receive Path for a High-Speed Transceiver Macrocell

This block turns recovered serial line levels into bytes for a protocol engine. Clock and data recovery sits upstream. It presents one (dp, dm) level pair per bit time and marks that pair with a strobe. The block looks for the packet preamble, a run of alternating J/K states that closes with two K states. Once the preamble is found, it decodes the NRZI signalling and removes stuffed bits. It then packs the data least significant bit first and hands each byte to the consumer with a one-clock valid pulse.

A single-ended zero closes the packet. A stuffing violation or a single-ended one aborts it, and so does a packet that ends part-way through a byte; each of these raises an error pulse that is timed like a data byte. Independently of packet reception, the block reports a two-bit line state. In normal operation that state passes through a synchroniser. In suspend it bypasses the synchroniser and follows the line directly.

Top module: `utmi_rx_deser`

## Requirements
- R1: With bit_en high, a K sample that follows a K sample starts a packet if at least SYNC_MIN_ALT (default 3) alternating J/K transitions came right before it. rx_active rises in the clock after that sample and stays high until the packet ends. J is dp=1,dm=0 and K is dp=0,dm=1.
- R2: A K-K pair that follows fewer than SYNC_MIN_ALT alternations does not start a packet, and rx_active stays low.
- R3: Inside a packet, a sample equal to the previous one decodes as 1 and a changed sample decodes as 0. Bits fill each byte least significant bit first. When a byte completes, rx_data carries it and rx_valid is high for exactly one clock, in the clock after its last bit was sampled.
- R4: After six decoded ones in a row, the next bit must be a zero. That bit is discarded and never enters a byte.
- R5: A seventh decoded one in a row aborts the packet. rx_error pulses for one clock and rx_active falls in the same clock. No further bytes or packets are taken until a J sample is seen.
- R6: An SE0 sample (dp=0,dm=0) inside a packet ends it and drops rx_active in the next clock. rx_error pulses in that same clock only if the number of data bits received is not a multiple of 8.
- R7: An SE1 sample (dp=1,dm=1) inside a packet ends it with an rx_error pulse.
- R8: Line samples are taken only in clocks where bit_en is high. Level changes at other times do not alter the received bytes.
- R9: line_state is {dm, dp}, so 00 is SE0, 01 is J, 10 is K and 11 is SE1. While suspend_n is high, line_state lags the lines by LS_STAGES clocks (default 2).
- R10: While suspend_n is low, line_state follows dp and dm combinationally, with no clock delay.
- R11: While rst is high and right after it, rx_valid, rx_active and rx_error are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel-side clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | Marks the clock in which dp_lvl/dm_lvl hold a new bit sample |
| dp_lvl | input | 1 | Recovered level of the positive data line |
| dm_lvl | input | 1 | Recovered level of the negative data line |
| suspend_n | input | 1 | Low selects suspend, in which line_state bypasses the synchroniser |
| rx_data | output | DATA_W | Last completed received byte |
| rx_valid | output | 1 | One-clock pulse when rx_data holds a new byte |
| rx_active | output | 1 | High while a packet is being received |
| rx_error | output | 1 | One-clock pulse on a stuffing, SE1 or alignment error |
| line_state | output | 2 | {dm, dp} line state |

## Verification
If the run-of-ones counter holds a wrong value, the fault shows up within one byte: either a stuffed zero reaches rx_data and shifts every later bit, or a valid stream raises rx_error at its seventh bit. If the NRZI reference level is wrong, the first data byte of the packet comes out corrupted. If the bit index is wrong, either rx_valid arrives early or late, or an aligned SE0 reports an error. A fault in the preamble tracker shows up only at the K-K sample, where rx_active either fails to rise or rises on a short pattern.

// File: rtl/utmi_rx_pkg.sv
package utmi_rx_pkg;

  // Line symbol encoding: bit 0 = dp, bit 1 = dm
  typedef enum logic [1:0] {
    LN_SE0 = 2'b00,
    LN_J   = 2'b01,
    LN_K   = 2'b10,
    LN_SE1 = 2'b11
  } line_t;

  typedef enum logic [1:0] {
    ST_HUNT  = 2'b00,
    ST_PKT   = 2'b01,
    ST_DRAIN = 2'b10
  } rx_state_t;

  // NRZI: unchanged level carries a one, a change carries a zero
  function automatic logic nrzi_bit(line_t cur, line_t prv);
    return cur == prv;
  endfunction

  // True when two samples form a J/K alternation
  function automatic logic is_flip(line_t cur, line_t prv);
    return (cur == LN_J && prv == LN_K) || (cur == LN_K && prv == LN_J);
  endfunction

endpackage

// File: rtl/utmi_ls_tracker.sv
module utmi_ls_tracker #(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       suspend_n,
  input  logic [1:0] raw_ls,
  output logic [1:0] line_state
);
  logic [1:0] sync_q;

  generate
    if (STAGES == 0) begin : g_nosync
      assign sync_q = raw_ls;
    end else begin : g_sync
      logic [1:0] pipe [STAGES];
      always_ff @(posedge clk) begin
        if (rst) pipe[0] <= 2'b00;
        else     pipe[0] <= raw_ls;
      end
      for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
          if (rst) pipe[i] <= 2'b00;
          else     pipe[i] <= pipe[i-1];
        end
      end
      assign sync_q = pipe[STAGES-1];
    end
  endgenerate

  // Suspend: bypass the synchroniser
  assign line_state = suspend_n ? sync_q : raw_ls;

endmodule

// File: rtl/utmi_rx_decoder.sv
module utmi_rx_decoder
  import utmi_rx_pkg::*;
#(
  parameter int STUFF_RUN    = 6,
  parameter int SYNC_MIN_ALT = 3
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  bit_en,
  input  line_t sym,
  output logic  sop_evt,
  output logic  bit_vld,
  output logic  bit_val,
  output logic  pkt_end,
  output logic  viol_err,
  output logic  pkt_active
);
  localparam int ONES_W = $clog2(STUFF_RUN + 1);
  localparam int ALT_W  = $clog2(SYNC_MIN_ALT + 1);

  rx_state_t         state;
  line_t             prev_sym;
  logic [ALT_W-1:0]  alt_cnt;
  logic [ONES_W-1:0] ones_cnt;

  logic flip, dbit, data_sym, stuff_slot, in_pkt, alt_full;

  always_comb begin
    flip       = is_flip(sym, prev_sym);
    dbit       = nrzi_bit(sym, prev_sym);
    data_sym   = (sym == LN_J) || (sym == LN_K);
    stuff_slot = (ones_cnt == ONES_W'(STUFF_RUN));
    in_pkt     = (state == ST_PKT);
    alt_full   = (alt_cnt == ALT_W'(SYNC_MIN_ALT));
    sop_evt    = bit_en && (state == ST_HUNT) && (sym == LN_K) &&
                 (prev_sym == LN_K) && alt_full;
    pkt_end    = bit_en && in_pkt && (sym == LN_SE0);
    viol_err   = bit_en && in_pkt &&
                 ((sym == LN_SE1) || (data_sym && stuff_slot && dbit));
    bit_vld    = bit_en && in_pkt && data_sym && !stuff_slot;
    bit_val    = dbit;
  end

  assign pkt_active = in_pkt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_HUNT;
      prev_sym <= LN_J;
      alt_cnt  <= '0;
      ones_cnt <= '0;
    end else if (bit_en) begin
      prev_sym <= sym;
      case (state)
        ST_HUNT: begin
          if (sop_evt) begin
            state    <= ST_PKT;
            alt_cnt  <= '0;
            ones_cnt <= '0;
          end else if (flip) begin
            if (!alt_full) alt_cnt <= alt_cnt + ALT_W'(1);
          end else begin
            alt_cnt <= '0;
          end
        end
        ST_PKT: begin
          if (pkt_end || viol_err) begin
            state    <= ST_DRAIN;
            ones_cnt <= '0;
          end else if (stuff_slot) begin
            ones_cnt <= '0;
          end else if (dbit) begin
            ones_cnt <= ones_cnt + ONES_W'(1);
          end else begin
            ones_cnt <= '0;
          end
        end
        default: begin
          if (sym == LN_J) begin
            state   <= ST_HUNT;
            alt_cnt <= '0;
          end
        end
      endcase
    end
  end

  a_r4_ones_bound: assert property (@(posedge clk) disable iff (rst)
    ones_cnt <= ONES_W'(STUFF_RUN));
  a_r1_sop_active: assert property (@(posedge clk) disable iff (rst)
    sop_evt |=> pkt_active);
  a_r5_viol_closes: assert property (@(posedge clk) disable iff (rst)
    viol_err |=> !pkt_active);

endmodule

// File: rtl/utmi_rx_assembler.sv
module utmi_rx_assembler #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sop_evt,
  input  logic              bit_vld,
  input  logic              bit_val,
  input  logic              pkt_end,
  input  logic              viol_err,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              rx_error
);
  localparam int IDX_W = $clog2(DATA_W);

  logic [DATA_W-1:0] shreg;
  logic [IDX_W-1:0]  idx;
  logic              last_bit;
  logic [DATA_W-1:0] next_byte;

  assign last_bit  = (idx == IDX_W'(DATA_W - 1));
  assign next_byte = {bit_val, shreg[DATA_W-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg    <= '0;
      idx      <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
      rx_error <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      rx_error <= viol_err || (pkt_end && (idx != '0));
      if (sop_evt || pkt_end || viol_err) begin
        idx <= '0;
      end else if (bit_vld) begin
        shreg <= next_byte;
        if (last_bit) begin
          rx_data  <= next_byte;
          rx_valid <= 1'b1;
          idx      <= '0;
        end else begin
          idx <= idx + IDX_W'(1);
        end
      end
    end
  end

  a_r3_valid_single: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);
  a_r3_valid_from_bit: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> $past(bit_vld));

endmodule

// File: rtl/utmi_rx_deser.sv
module utmi_rx_deser
  import utmi_rx_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int STUFF_RUN    = 6,
  parameter int SYNC_MIN_ALT = 3,
  parameter int LS_STAGES    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic              dp_lvl,
  input  logic              dm_lvl,
  input  logic              suspend_n,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              rx_active,
  output logic              rx_error,
  output logic [1:0]        line_state
);
  line_t sym;
  logic  sop_evt, bit_vld, bit_val, pkt_end, viol_err;

  assign sym = line_t'({dm_lvl, dp_lvl});

  utmi_ls_tracker #(.STAGES(LS_STAGES)) u_ls (
    .clk        (clk),
    .rst        (rst),
    .suspend_n  (suspend_n),
    .raw_ls     ({dm_lvl, dp_lvl}),
    .line_state (line_state)
  );

  utmi_rx_decoder #(.STUFF_RUN(STUFF_RUN), .SYNC_MIN_ALT(SYNC_MIN_ALT)) u_dec (
    .clk        (clk),
    .rst        (rst),
    .bit_en     (bit_en),
    .sym        (sym),
    .sop_evt    (sop_evt),
    .bit_vld    (bit_vld),
    .bit_val    (bit_val),
    .pkt_end    (pkt_end),
    .viol_err   (viol_err),
    .pkt_active (rx_active)
  );

  utmi_rx_assembler #(.DATA_W(DATA_W)) u_asm (
    .clk      (clk),
    .rst      (rst),
    .sop_evt  (sop_evt),
    .bit_vld  (bit_vld),
    .bit_val  (bit_val),
    .pkt_end  (pkt_end),
    .viol_err (viol_err),
    .rx_data  (rx_data),
    .rx_valid (rx_valid),
    .rx_error (rx_error)
  );

  a_r6_error_no_active: assert property (@(posedge clk) disable iff (rst)
    rx_error |-> !rx_active);

endmodule

// File: tb/utmi_rx_deser_tb.sv
module utmi_rx_deser_tb;
  localparam int CLK_NS = 5;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_en = 1'b0;
  logic       dp = 1'b1;
  logic       dm = 1'b0;
  logic       suspend_n = 1'b1;
  logic [7:0] rx_data;
  logic       rx_valid, rx_active, rx_error;
  logic [1:0] line_state;

  int checks = 0;
  int failures = 0;

  logic       lvl;
  int         ones;
  int         n_got, n_err;
  bit         any_active, last_active, last_err, noisy;
  logic [7:0] got [8];

  always #(CLK_NS / 2.0) clk = ~clk;

  utmi_rx_deser u_dut (
    .clk(clk), .rst(rst), .bit_en(bit_en), .dp_lvl(dp), .dm_lvl(dm),
    .suspend_n(suspend_n), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_active(rx_active), .rx_error(rx_error), .line_state(line_state)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_log();
    n_got = 0; n_err = 0; any_active = 0;
  endtask

  task automatic send_sym(input logic p, input logic m);
    @(negedge clk); dp = p; dm = m; bit_en = 1'b1;
    @(negedge clk); bit_en = 1'b0;
    if (rx_valid) begin
      if (n_got < 8) got[n_got] = rx_data;
      n_got++;
    end
    if (rx_error) n_err++;
    if (rx_active) any_active = 1;
    last_active = rx_active;
    last_err    = rx_error;
    if (noisy) begin
      dp = ~p; dm = ~m;
      @(negedge clk); dp = p; dm = m;
    end
  endtask

  task automatic send_level(input logic l);
    send_sym(l, ~l);
  endtask

  // Encode one data bit: one keeps the level, zero toggles it; stuff after six ones
  task automatic send_bit(input logic b);
    if (!b) lvl = ~lvl;
    send_level(lvl);
    if (b) ones++; else ones = 0;
    if (ones == 6) begin
      lvl = ~lvl;
      send_level(lvl);
      ones = 0;
    end
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) send_bit(v[i]);
  endtask

  task automatic send_sync();
    send_level(1'b1);
    for (int i = 0; i < 7; i++) send_level(i[0]);   // K J K J K J K
    send_level(1'b0);                                // closing K
    lvl = 1'b0; ones = 0;
  endtask

  task automatic send_eop_tail();
    send_sym(1'b0, 1'b0);
    send_level(1'b1);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(!rx_active && !rx_valid && !rx_error, "R11 in reset", rx_active, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!rx_active && !rx_valid && !rx_error, "R11 after reset", rx_active, 0);
  endtask

  task automatic t_line_state();
    @(negedge clk); dp = 1'b1; dm = 1'b1;
    @(negedge clk);
    chk(line_state == 2'b01, "R9 one clock: still J", line_state, 1);
    @(negedge clk);
    chk(line_state == 2'b11, "R9 two clocks: SE1", line_state, 3);
    suspend_n = 1'b0;
    dp = 1'b0; dm = 1'b1;
    #1;
    chk(line_state == 2'b10, "R10 suspend K immediate", line_state, 2);
    dp = 1'b0; dm = 1'b0;
    #1;
    chk(line_state == 2'b00, "R10 suspend SE0 immediate", line_state, 0);
    @(negedge clk); dp = 1'b1; dm = 1'b0; suspend_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(line_state == 2'b01, "R9 idle J", line_state, 1);
  endtask

  task automatic t_plain_packet();
    clear_log();
    send_sync();
    chk(last_active, "R1 active after sync", last_active, 1);
    send_byte(8'hA5);
    send_byte(8'h3C);
    send_sym(1'b0, 1'b0);
    chk(!last_active, "R6 active drops on SE0", last_active, 0);
    chk(!last_err, "R6 aligned EOP no error", last_err, 0);
    send_eop_tail();
    chk(n_got == 2, "R3 byte count", n_got, 2);
    chk(got[0] == 8'hA5, "R3 first byte", got[0], 8'hA5);
    chk(got[1] == 8'h3C, "R3 second byte", got[1], 8'h3C);
    chk(n_err == 0, "R3 no errors", n_err, 0);
  endtask

  task automatic t_stuffed_packet();
    clear_log();
    send_sync();
    send_byte(8'hFF);
    send_byte(8'hFF);
    send_byte(8'h3F);
    send_sym(1'b0, 1'b0);
    send_eop_tail();
    chk(n_got == 3, "R4 byte count", n_got, 3);
    chk(got[0] == 8'hFF && got[1] == 8'hFF, "R4 ones bytes", got[1], 8'hFF);
    chk(got[2] == 8'h3F, "R4 stuff inside byte", got[2], 8'h3F);
    chk(n_err == 0, "R4 no errors", n_err, 0);
  endtask

  task automatic t_gated_noise();
    clear_log();
    noisy = 1;
    send_sync();
    send_byte(8'h5A);
    send_byte(8'hC3);
    noisy = 0;
    send_sym(1'b0, 1'b0);
    send_eop_tail();
    chk(n_got == 2 && got[0] == 8'h5A, "R8 byte0 under noise", got[0], 8'h5A);
    chk(got[1] == 8'hC3, "R8 byte1 under noise", got[1], 8'hC3);
    chk(n_err == 0, "R8 no errors", n_err, 0);
  endtask

  task automatic t_short_sync();
    clear_log();
    send_level(1'b1);
    send_level(1'b0);
    send_level(1'b0);
    send_level(1'b1);
    send_level(1'b1);
    chk(!any_active, "R2 short preamble ignored", any_active, 0);
  endtask

  task automatic t_stuff_violation();
    clear_log();
    send_sync();
    for (int i = 0; i < 6; i++) send_level(1'b0);
    chk(n_err == 0 && last_active, "R5 six ones ok", n_err, 0);
    send_level(1'b0);
    chk(last_err, "R5 seventh one error", last_err, 1);
    chk(!last_active, "R5 active drops with error", last_active, 0);
    any_active = 0;
    send_level(1'b0);
    send_level(1'b0);
    chk(!any_active && n_err == 1 && n_got == 0, "R5 ignored until J", n_err, 1);
    send_level(1'b1);
  endtask

  task automatic t_short_eop();
    clear_log();
    send_sync();
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
    send_sym(1'b0, 1'b0);
    chk(last_err, "R6 misaligned EOP error", last_err, 1);
    chk(!last_active, "R6 active drops", last_active, 0);
    send_eop_tail();
    chk(n_err == 1 && n_got == 0, "R6 single error pulse", n_err, 1);
  endtask

  task automatic t_se1_abort();
    clear_log();
    send_sync();
    send_byte(8'h55);
    send_sym(1'b1, 1'b1);
    chk(last_err && !last_active, "R7 SE1 aborts with error", last_err, 1);
    chk(n_got == 1 && got[0] == 8'h55, "R7 prior byte intact", got[0], 8'h55);
    send_level(1'b1);
  endtask

  initial begin
    #(CLK_NS * 150000);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    noisy = 0; lvl = 1'b1; ones = 0;
    clear_log();
    t_reset();
    t_line_state();
    t_plain_packet();
    t_stuffed_packet();
    t_gated_noise();
    t_short_sync();
    t_stuff_violation();
    t_short_eop();
    t_se1_abort();
    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule